// File: doc/BRIEF.md
# Byte-Serial Wide Add/Subtract Unit

This block adds or subtracts integers that are wider than its byte-wide datapath. A wide operand pair is fed in one byte pair per cycle, least significant byte first. A marker flags the first byte pair of each operand, and a second marker flags the last. A one-bit link register carries the carry (for addition) or the borrow (for subtraction) of each byte into the next, more significant byte of the same operation. Subtraction runs on the same adder: the subtrahend byte is inverted and the carry-in is set to the complement of the pending borrow.

Every accepted byte pair yields a registered result byte one cycle later. The result comes with the carry/borrow out of that byte, a last-byte marker, and a signed-overflow flag. The signed-overflow flag is only raised on the last byte of an operation. An operation of any length is handled: a single-byte operation sets both markers on the same beat. Idle cycles may fall between the bytes of one operation.

Top module: `mpa_unit`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, the link register (to "no carry / no borrow") and the held mode (to addition). A byte accepted after reset without `in_first` is added with carry-in 0.
- R2: Each beat with `in_valid` high gives `out_valid` high on the next clock edge. `out_byte` is (A + B + carry-in) mod 256 for addition, and `out_carry` is the carry out of bit 7.
- R3: On a beat with `in_first` high, the stored link value is ignored. Addition starts with carry-in 0, and subtraction starts with no borrow.
- R4: On a beat without `in_first`, the link value stored by the previous accepted beat is used. The link register holds the same value as the `out_carry` just reported.
- R5: Subtraction is selected by `in_sub`=1 (0 selects addition). It yields `out_byte` = (A − B − borrow-in) mod 256 and `out_carry` = 1 exactly when A < B + borrow-in. That is, `out_carry` is the borrow out, and it is computed as A + ~B + (1 − borrow-in).
- R6: When the last byte of a subtraction reports `out_carry`=1, the full-width unsigned difference is negative. When the last byte of an addition reports `out_carry`=1, the full-width unsigned sum does not fit.
- R7: On a beat with `in_last` high, `out_ovf` equals the carry into bit 7 XOR the carry out of bit 7. This is 1 exactly when the signed result of the top byte lies outside [−128, 127]. On other beats `out_ovf` is 0.
- R8: `out_last` repeats the `in_last` value of the beat that produced the result.
- R9: `in_sub` is sampled only on a beat with `in_first`. On later beats of the same operation it has no effect on the result.
- R10: A cycle with `in_valid` low produces `out_valid` low on the next edge and leaves the link register and the held mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte pair present this cycle |
| in_first | input | 1 | Least significant byte pair of a new operation |
| in_last | input | 1 | Most significant byte pair of the operation |
| in_sub | input | 1 | 1 = subtract, 0 = add (sampled with in_first) |
| in_a | input | 8 | Minuend / first addend byte |
| in_b | input | 8 | Subtrahend / second addend byte |
| out_valid | output | 1 | Result byte present |
| out_byte | output | 8 | Result byte |
| out_carry | output | 1 | Carry out (add) or borrow out (subtract) of this byte |
| out_ovf | output | 1 | Signed overflow, last byte only |
| out_last | output | 1 | Result belongs to the last byte |

## Verification
Every result is due exactly one clock edge after the beat that carries its byte pair. The link value that beat writes is first used on the next accepted beat, whether or not idle cycles come between them. The bench drives each beat on a falling edge and lets one rising edge pass. It then compares all five outputs on the following falling edge against a behavioural integer model, which keeps its own running carry or borrow. Idle beats are compared in the same slot for a low `out_valid`, and the link state they must preserve is then observed through the result of the next non-first byte.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } mpa_op_e;

endpackage

// File: rtl/mpa_byte_adder.sv
module mpa_byte_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_into_msb,
  output logic         c_out
);

  localparam int LOW_W = W - 1;

  // Packs {carry out, carry into msb, sum}; the sum is split at the msb so
  // the carry into the top bit is visible for signed overflow.
  function automatic logic [W+1:0] split_add(input logic [W-1:0] x,
                                             input logic [W-1:0] y,
                                             input logic         ci);
    logic [LOW_W:0] low;
    logic [1:0]     top;
    low = {1'b0, x[LOW_W-1:0]} + {1'b0, y[LOW_W-1:0]} + {{LOW_W{1'b0}}, ci};
    top = {1'b0, x[W-1]} + {1'b0, y[W-1]} + {1'b0, low[LOW_W]};
    return {top[1], low[LOW_W], top[0], low[LOW_W-1:0]};
  endfunction

  logic [W+1:0] packed_res;

  always_comb begin
    packed_res = split_add(a, b, cin);
    sum        = packed_res[W-1:0];
    c_into_msb = packed_res[W];
    c_out      = packed_res[W+1];
  end

endmodule

// File: rtl/mpa_link_ctl.sv
module mpa_link_ctl
  import mpa_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    in_valid,
  input  logic    in_first,
  input  logic    in_sub,
  input  logic    adder_cout,
  output mpa_op_e op_cur,
  output logic    adder_cin,
  output logic    link_out,
  output logic    flag_q
);

  mpa_op_e mode_q;
  logic    link_in;

  always_comb begin
    op_cur    = in_first ? mpa_op_e'(in_sub) : mode_q;
    link_in   = in_first ? 1'b0 : flag_q;
    adder_cin = (op_cur == OP_SUB) ? ~link_in : link_in;
    link_out  = (op_cur == OP_SUB) ? ~adder_cout : adder_cout;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      mode_q <= OP_ADD;
    end else if (in_valid) begin
      flag_q <= link_out;
      mode_q <= op_cur;
    end
  end

endmodule

// File: rtl/mpa_out_stage.sv
module mpa_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_last,
  input  logic [W-1:0] sum,
  input  logic         link_out,
  input  logic         c_into_msb,
  input  logic         c_out,
  output logic         out_valid,
  output logic [W-1:0] out_byte,
  output logic         out_carry,
  output logic         out_ovf,
  output logic         out_last
);

  function automatic logic signed_ovf(input logic cm, input logic co);
    return cm ^ co;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_carry <= 1'b0;
      out_ovf   <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_byte  <= sum;
        out_carry <= link_out;
        out_ovf   <= in_last & signed_ovf(c_into_msb, c_out);
        out_last  <= in_last;
      end
    end
  end

endmodule

// File: rtl/mpa_unit.sv
module mpa_unit
  import mpa_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_first,
  input  logic         in_last,
  input  logic         in_sub,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  output logic [W-1:0] out_byte,
  output logic         out_carry,
  output logic         out_ovf,
  output logic         out_last
);

  mpa_op_e      op_cur;
  logic         adder_cin;
  logic         adder_cout;
  logic         adder_cmsb;
  logic         link_out;
  logic         link_flag;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;

  assign b_eff = (op_cur == OP_SUB) ? ~in_b : in_b;

  mpa_link_ctl u_link (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_first   (in_first),
    .in_sub     (in_sub),
    .adder_cout (adder_cout),
    .op_cur     (op_cur),
    .adder_cin  (adder_cin),
    .link_out   (link_out),
    .flag_q     (link_flag)
  );

  mpa_byte_adder #(.W(W)) u_add (
    .a          (in_a),
    .b          (b_eff),
    .cin        (adder_cin),
    .sum        (sum),
    .c_into_msb (adder_cmsb),
    .c_out      (adder_cout)
  );

  mpa_out_stage #(.W(W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .sum        (sum),
    .link_out   (link_out),
    .c_into_msb (adder_cmsb),
    .c_out      (adder_cout),
    .out_valid  (out_valid),
    .out_byte   (out_byte),
    .out_carry  (out_carry),
    .out_ovf    (out_ovf),
    .out_last   (out_last)
  );

endmodule

// File: rtl/mpa_unit_chk.sv
module mpa_unit_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_first,
  input logic in_last,
  input logic in_sub,
  input logic out_valid,
  input logic out_carry,
  input logic out_ovf,
  input logic out_last,
  input logic link_flag,
  input logic adder_cin
);

  p_reset_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_first_cin_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_first) |-> (adder_cin == in_sub));

  p_link_match_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (link_flag == out_carry));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |-> !out_ovf);

  p_last_echo_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_last == $past(in_last)));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(link_flag)));

endmodule

bind mpa_unit mpa_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_first  (in_first),
  .in_last   (in_last),
  .in_sub    (in_sub),
  .out_valid (out_valid),
  .out_carry (out_carry),
  .out_ovf   (out_ovf),
  .out_last  (out_last),
  .link_flag (link_flag),
  .adder_cin (adder_cin)
);

// File: tb/mpa_unit_tb.sv
module mpa_unit_tb;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_sub = 1'b0;
  logic [7:0] in_a = '0, in_b = '0;
  logic       out_valid, out_carry, out_ovf, out_last;
  logic [7:0] out_byte;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural model state
  int m_sub = 0;
  int m_link = 0;

  always #(PERIOD/2) clk = ~clk;

  mpa_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_sub(in_sub), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_byte(out_byte), .out_carry(out_carry),
    .out_ovf(out_ovf), .out_last(out_last)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives one beat at a falling edge, checks all outputs one edge later.
  task automatic beat(input int a, input int b, input bit first, input bit last,
                      input bit sub, input string req, output int res);
    int sa, sb, s, tot, e_byte, e_cy, e_ovf;
    in_valid = 1; in_first = first; in_last = last; in_sub = sub;
    in_a = a[7:0]; in_b = b[7:0];
    if (first) begin m_sub = sub; m_link = 0; end
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    if (m_sub == 0) begin
      tot = a + b + m_link;
      e_byte = tot % 256; e_cy = tot / 256;
      s = sa + sb + m_link;
    end else begin
      tot = a - b - m_link;
      e_cy = (tot < 0) ? 1 : 0;
      e_byte = (tot + 256) % 256;
      s = sa - sb - m_link;
    end
    e_ovf = (last && (s > 127 || s < -128)) ? 1 : 0;
    m_link = e_cy;
    @(posedge clk); @(negedge clk);
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " byte"},  int'(out_byte), e_byte);
    chk({req, " carry"}, int'(out_carry), e_cy);
    chk({req, " ovf"},   int'(out_ovf), e_ovf);
    chk({req, " last"},  int'(out_last), int'(last));
    res = int'(out_byte) | (int'(out_carry) << 8);
  endtask

  task automatic idle(input string req);
    in_valid = 0; in_a = 8'hA5; in_b = 8'h5A; in_sub = ~in_sub;
    @(posedge clk); @(negedge clk);
    chk({req, " idle valid"}, int'(out_valid), 0);
  endtask

  initial begin
    int r0, r1, r2, r3;
    @(negedge clk); @(negedge clk);
    chk("R1 reset valid", int'(out_valid), 0);
    rst = 0;
    // R1: non-first byte after reset adds with no carry-in
    beat(8'hF0, 8'h0F, 0, 1, 1, "R1", r0);
    chk("R1 post-reset sum", r0, 32'h0FF);
    // R2/R4: 0x453F + 0xA1C2 = 0xE701
    beat(8'h3F, 8'hC2, 1, 0, 0, "R2", r0);
    beat(8'h45, 8'hA1, 0, 1, 0, "R4", r1);
    chk("R4 16-bit sum", ((r1 & 255) << 8) | (r0 & 255), 16'hE701);
    // R3: previous op left carry; new first byte must ignore it
    beat(8'hFF, 8'hFF, 1, 1, 0, "R3 carry", r0);
    beat(8'h01, 8'h02, 1, 1, 0, "R3", r0);
    chk("R3 fresh add", r0, 3);
    // R5/R6: 0xB23A - 0x3775 = 0x7AC5, no final borrow
    beat(8'h3A, 8'h75, 1, 0, 1, "R5", r0);
    beat(8'hB2, 8'h37, 0, 1, 1, "R6", r1);
    chk("R5 16-bit diff", ((r1 & 255) << 8) | (r0 & 255), 16'h7AC5);
    chk("R6 no final borrow", r1 >> 8, 0);
    // R6: negative difference 0x0100 - 0x0200
    beat(8'h00, 8'h00, 1, 0, 1, "R6 lo", r0);
    beat(8'h01, 8'h02, 0, 1, 1, "R6 hi", r1);
    chk("R6 final borrow", r1 >> 8, 1);
    // R7: +92 + +78 overflows on last; intermediate ovf forced low
    beat(8'h5C, 8'h4E, 1, 0, 0, "R7 mid", r0);
    beat(8'h5C, 8'h4E, 0, 1, 0, "R7 last", r0);
    beat(8'hA4, 8'hB2, 1, 1, 0, "R7 neg", r0);
    beat(8'h5C, 8'hB2, 1, 1, 0, "R7 none", r0);
    beat(8'h80, 8'h01, 1, 1, 1, "R7 sub", r0);
    // R9: in_sub flips mid-operand; mode stays add
    beat(8'hFF, 8'h01, 1, 0, 0, "R9 lo", r0);
    beat(8'h10, 8'h20, 0, 1, 1, "R9 hi", r1);
    chk("R9 mode held", r1 & 255, 8'h31);
    // R10: idle gaps keep link and mode (subtract with borrow)
    beat(8'h00, 8'h01, 1, 0, 1, "R10 lo", r0);
    idle("R10");
    idle("R10");
    beat(8'h05, 8'h01, 0, 0, 0, "R10 mid", r1);
    chk("R10 borrow kept", r1 & 255, 8'h03);
    beat(8'h00, 8'h00, 0, 1, 0, "R10 hi", r2);
    // R8 and random operations of 1..4 bytes
    for (int op = 0; op < 150; op++) begin
      int len; bit sb;
      len = 1 + ($urandom % 4);
      sb = 1'($urandom % 2);
      for (int k = 0; k < len; k++) begin
        beat($urandom % 256, $urandom % 256, k == 0, k == len - 1,
             (k == 0) ? sb : 1'($urandom % 2), "R8 rand", r3);
        if ($urandom % 5 == 0) idle("R10 rand");
      end
    end
    in_valid = 0;
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule